// File: doc/BRIEF.md
# Weak Until Property Monitor

This block checks at runtime that, after a trigger, a condition `p` keeps holding until a release condition `q` arrives. A trigger sampled on one rising edge opens a wait that starts on the next cycle. While the wait is open, each cycle either releases it, carries it forward, or reports a failure. The property is weak: a wait that is never released never fails.

The mode input selects one of two variants, and it must stay constant outside reset. In the plain variant, the wait is released in any cycle where `q` is high, and a cycle fails only when both `p` and `q` are low. In the inclusive variant, the release needs `p` and `q` high in the same cycle, and any cycle with `p` low fails.

All live attempts share one wait bit. If a trigger arrives while a wait is already open, it merges into that wait. The fail pulse therefore fires at most once per cycle, and the saturating counter counts failing cycles rather than failing attempts.

Top module: `weak_until_mon`

## Requirements
- R1: A trigger sampled high at a rising edge makes `waiting` high in the following cycle, in both modes.
- R2: While `waiting` is high and `p`=1, `q`=0 are sampled, `waiting` is high again in the next cycle. With no trigger, `waiting` is high in a cycle only if it was high in the cycle before and `p`=1, `q`=0 were sampled then.
- R3: With `incl_mode`=0, `fail` is high in a cycle exactly when `waiting` is high and `p`=0 and `q`=0.
- R4: With `incl_mode`=0, a cycle in which `waiting` is high and `q`=1 releases the wait without failing. `waiting` is then low in the next cycle unless a new trigger was sampled.
- R5: With `incl_mode`=1, `fail` is high in a cycle exactly when `waiting` is high and `p`=0, whatever the value of `q`.
- R6: With `incl_mode`=1, the wait is released only in a cycle with `p`=1 and `q`=1. A cycle with `q`=1 and `p`=0 fails instead of releasing.
- R7: A wait that sees `p`=1, `q`=0 forever stays active and never raises `fail`.
- R8: Overlapping triggers merge into one wait. `fail_cnt` increases by exactly one after each cycle in which `fail` is high, however many triggers are outstanding.
- R9: `fail_cnt` saturates at its all-ones value (15 for `CNT_W`=4) and holds there.
- R10: Synchronous reset clears the wait and `fail_cnt`. In the first cycle after reset is released, both `waiting` and `fail` are low.
- R11: With `incl_mode`=0, `p` tied to 0 and `q` tied to 1 never produce a failure, whatever the trigger does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| incl_mode | input | 1 | 0 selects the plain variant, 1 selects the inclusive variant; must stay static outside reset |
| trig | input | 1 | Starts an attempt whose wait opens on the next cycle |
| p | input | 1 | Condition that must hold while waiting |
| q | input | 1 | Release condition |
| fail | output | 1 | High in each cycle in which the open wait fails |
| waiting | output | 1 | High in each cycle in which a wait is open |
| fail_cnt | output | CNT_W | Saturating count of failing cycles |

## Verification
The assertions assume that `incl_mode` changes only while `rst` is high, and that `trig`, `p` and `q` have known values on every edge after reset. The stimulus drives every input on the falling clock edge. It changes the mode only inside a reset pulse, and it sweeps every three-cycle combination of trigger, `p` and `q` in both modes, starting each combination from a fresh reset. Longer directed runs then cover the pending-forever case, the saturation of the counter, and the tied-constant operands.

// File: rtl/weak_until_mon.sv
module weak_until_mon #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             incl_mode,
  input  logic             trig,
  input  logic             p,
  input  logic             q,
  output logic             fail,
  output logic             waiting,
  output logic [CNT_W-1:0] fail_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic trig_d;
  logic carry_r;
  logic need;
  logic carry_nx;

  assign waiting  = trig_d | carry_r;
  assign need     = incl_mode ? p : (p | q);
  assign fail     = waiting & ~need;
  assign carry_nx = waiting & p & ~q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d   <= 1'b0;
      carry_r  <= 1'b0;
      fail_cnt <= '0;
    end else begin
      trig_d  <= trig;
      carry_r <= carry_nx;
      if (fail && fail_cnt != CNT_MAX) fail_cnt <= fail_cnt + 1'b1;
    end
  end

  a_r1_trig_opens: assert property (@(posedge clk) disable iff (rst)
    trig |=> waiting);
  a_r2_carry: assert property (@(posedge clk) disable iff (rst)
    waiting && p && !q |=> waiting);
  a_r4_plain_release: assert property (@(posedge clk) disable iff (rst)
    !incl_mode && waiting && q && !trig |=> !waiting);
  a_r6_incl_release: assert property (@(posedge clk) disable iff (rst)
    incl_mode && waiting && p && q && !trig |=> !waiting);
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    fail && fail_cnt != CNT_MAX |=> fail_cnt == $past(fail_cnt) + 1'b1);
  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    fail_cnt == CNT_MAX |=> fail_cnt == CNT_MAX);
  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fail && !waiting);
endmodule

// File: tb/tb_weak_until_mon.sv
module tb_weak_until_mon;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic incl_mode = 1'b0;
  logic trig = 1'b0;
  logic p = 1'b0;
  logic q = 1'b0;
  logic fail;
  logic waiting;
  logic [CW-1:0] fail_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic m_td, m_cr;
  int   m_cnt;

  always #5 clk = ~clk;

  weak_until_mon #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .incl_mode(incl_mode), .trig(trig), .p(p), .q(q),
    .fail(fail), .waiting(waiting), .fail_cnt(fail_cnt)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1; incl_mode = mode; trig = 0; p = 0; q = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_td = 0; m_cr = 0; m_cnt = 0;
  endtask

  task automatic step(input logic t, input logic pp, input logic qq);
    logic ew, ef;
    trig = t; p = pp; q = qq;
    #1;
    ew = m_td | m_cr;
    ef = ew & (incl_mode ? ~pp : ~(pp | qq));
    chk(int'(waiting), int'(ew), "R2 wait");
    chk(int'(fail), int'(ef), incl_mode ? "R5 fail" : "R3 fail");
    chk(int'(fail_cnt), m_cnt, "R8 count");
    @(posedge clk);
    m_td = t;
    m_cr = ew & pp & ~qq;
    if (ef && m_cnt < (1 << CW) - 1) m_cnt++;
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int mode = 0; mode < 2; mode++) begin
      for (int pat = 0; pat < 512; pat++) begin
        do_reset(mode[0]);
        #1;
        chk(int'(waiting), 0, "R10 wait after reset");
        chk(int'(fail), 0, "R10 fail after reset");
        for (int c = 0; c < 3; c++)
          step(pat[3*c+2], pat[3*c+1], pat[3*c]);
        step(0, 1, 1);
      end
    end

    do_reset(0);
    step(1, 0, 0);
    #1; chk(int'(waiting), 1, "R1 opens next cycle");
    step(0, 0, 1);
    #1; chk(int'(waiting), 0, "R4 released by q");
    chk(int'(fail_cnt), 0, "R4 no failure on release");

    do_reset(1);
    step(1, 0, 0);
    step(0, 0, 1);
    #1; chk(int'(fail_cnt), 1, "R6 q without p fails");
    do_reset(1);
    step(1, 0, 0);
    step(0, 1, 1);
    #1; chk(int'(waiting), 0, "R6 released by p and q");

    do_reset(0);
    step(1, 1, 0);
    for (int i = 0; i < 40; i++) step(0, 1, 0);
    #1; chk(int'(waiting), 1, "R7 still pending");
    chk(int'(fail_cnt), 0, "R7 never fails");

    do_reset(1);
    for (int i = 0; i < 25; i++) step(1, 0, i[0]);
    #1; chk(int'(fail_cnt), 15, "R9 saturated");
    step(1, 0, 0);
    #1; chk(int'(fail_cnt), 15, "R9 holds");

    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    m_td = 0; m_cr = 0; m_cnt = 0;
    #1; chk(int'(fail_cnt), 0, "R10 counter cleared");
    chk(int'(waiting), 0, "R10 wait cleared");

    do_reset(0);
    for (int i = 0; i < 60; i++) step(i[0] ^ i[2], 0, 1);
    #1; chk(int'(fail_cnt), 0, "R11 tied operands never fail");

    do_reset(0);
    step(1, 0, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    #1; chk(int'(fail_cnt), 2, "R8 one count per failing cycle");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule